// File: doc/BRIEF.md
# Paired Byte/Word Register Coprocessor

This block is an arithmetic helper that sits beside a small 8-bit host processor. The host hands it 16-bit instruction words, and each word names an operation and two registers. The block holds 32 byte-wide registers. The same storage can also be addressed as 16 word registers, where each word is an even register and the odd register just above it. Each instruction either copies a value, adds with carry, or applies a bitwise operation. Every instruction in the set comes in a byte form and a word form.

The host loads operands and collects results through a small memory-style port. Addresses 0 to 31 select the byte registers, and address 32 returns a status byte. The host tests the flags in that byte to choose its branches. Every instruction finishes at the clock edge that accepts it, so the busy output never rises. An instruction word that uses an undefined operation is discarded, and a sticky status bit records that it arrived.

Top module: `regpair_coproc`

## Requirements
- R1: After synchronous reset, every byte register reads 0, the status byte reads 0, and host_rdata is 0.
- R2: host_rdata presents, one clock after host_addr is sampled, byte register host_addr (0..31) or, at address 32, the status byte {4'b0, ILL, N, Z, C} (ILL in bit 3, C in bit 0); any higher address reads 0. Host writes with host_we to addresses 0..31 change that register; writes to higher addresses change nothing.
- R3: ins_word packs opcode[15:10], register field A[9:5] (destination and first source) and field B[4:0] (second source). The instruction executes at the clock edge that samples ins_valid high, so its result can be read in the next cycle, and busy stays 0.
- R4: Opcode bit 5 selects the word form. Word register Wn is {R(2n+1), R(2n)}, with the even register as the low byte. A word form ignores bit 0 of both register fields. Operations are selected by opcode bits 4:0: 0 copy, 1 add-with-carry, 2 AND, 3 OR, 4 XOR, 5 clear carry, 6 set carry.
- R5: The byte add-with-carry writes A = A + B + C into the byte register. C becomes the carry out of bit 7, Z is set when the 8-bit result is 0, and N copies bit 7. The neighbouring register is not touched.
- R6: The word add-with-carry works on the 16-bit pairs. C becomes the carry out of bit 15, Z reflects the 16-bit result, and N copies bit 15.
- R7: The copy operation (0) writes B into A. It leaves B and all flags unchanged.
- R8: AND (2), OR (3) and XOR (4) write A op B into A. They update Z and N and keep C.
- R9: Clear carry (5) sets C to 0 and set carry (6) sets C to 1. Neither changes any register, Z or N.
- R10: An opcode whose bits 4:0 are 7 or above changes no register and none of C, Z and N. It sets ILL, and ILL then stays set until reset, even after later legal instructions.
- R11: When a host write and an instruction write hit the same byte register at the same edge, the instruction's value is kept. When they hit different registers, both writes land. A host read sampled at that edge returns the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word present this cycle |
| ins_word | input | 16 | Packed instruction: opcode, field A, field B |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 6 | Host register/status address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| busy | output | 1 | Always low: no wait is ever needed |

## Verification
An instruction and a host port access can land on the same clock edge. That edge may carry a host write to the very byte the instruction overwrites, a host write to a different byte, or a host read of the byte being overwritten. The bench provokes all three by raising ins_valid and the host strobe on the same cycle. It then judges the result by reading back the target, the other byte, and the read data from that edge. The instruction's value must win on a clash, both writes must land otherwise, and the read must return the value from before the edge.

// File: rtl/coproc_pkg.sv
package coproc_pkg;
  localparam int OPW = 6;
  localparam int FNW = OPW - 1;

  localparam logic [FNW-1:0] FN_MOV = 5'd0;
  localparam logic [FNW-1:0] FN_ADC = 5'd1;
  localparam logic [FNW-1:0] FN_AND = 5'd2;
  localparam logic [FNW-1:0] FN_OR  = 5'd3;
  localparam logic [FNW-1:0] FN_XOR = 5'd4;
  localparam logic [FNW-1:0] FN_CLC = 5'd5;
  localparam logic [FNW-1:0] FN_SEC = 5'd6;

  typedef struct packed {
    logic ill;
    logic n;
    logic z;
    logic c;
  } flags_t;
endpackage

// File: rtl/coproc_decode.sv
module coproc_decode
  import coproc_pkg::*;
(
  input  logic [OPW-1:0] opc,
  output logic           legal,
  output logic           wide,
  output logic [FNW-1:0] fn,
  output logic           wr_reg,
  output logic           upd_c,
  output logic           upd_zn,
  output logic           force_c,
  output logic           force_val
);
  always_comb begin
    wide      = opc[OPW-1];
    fn        = opc[FNW-1:0];
    legal     = 1'b1;
    wr_reg    = 1'b0;
    upd_c     = 1'b0;
    upd_zn    = 1'b0;
    force_c   = 1'b0;
    force_val = 1'b0;
    case (fn)
      FN_MOV: wr_reg = 1'b1;
      FN_ADC: begin wr_reg = 1'b1; upd_c = 1'b1; upd_zn = 1'b1; end
      FN_AND, FN_OR, FN_XOR: begin wr_reg = 1'b1; upd_zn = 1'b1; end
      FN_CLC: force_c = 1'b1;
      FN_SEC: begin force_c = 1'b1; force_val = 1'b1; end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/coproc_alu.sv
module coproc_alu
  import coproc_pkg::*;
#(
  parameter int BW = 8,
  localparam int WW = 2 * BW
) (
  input  logic [WW-1:0]  a,
  input  logic [WW-1:0]  b,
  input  logic           wide,
  input  logic [FNW-1:0] fn,
  input  logic           cin,
  output logic [WW-1:0]  res,
  output logic           cout,
  output logic           zero,
  output logic           neg
);
  logic [WW:0]   sum_w;
  logic [BW:0]   sum_b;
  logic [WW-1:0] raw;

  always_comb begin
    sum_w = {1'b0, a} + {1'b0, b} + {{WW{1'b0}}, cin};
    sum_b = {1'b0, a[BW-1:0]} + {1'b0, b[BW-1:0]} + {{BW{1'b0}}, cin};
    case (fn)
      FN_ADC:  raw = wide ? sum_w[WW-1:0] : {{BW{1'b0}}, sum_b[BW-1:0]};
      FN_AND:  raw = a & b;
      FN_OR:   raw = a | b;
      FN_XOR:  raw = a ^ b;
      default: raw = b;
    endcase
    res  = wide ? raw : {{BW{1'b0}}, raw[BW-1:0]};
    cout = wide ? sum_w[WW] : sum_b[BW];
    zero = (res == '0);
    neg  = wide ? res[WW-1] : res[BW-1];
  end
endmodule

// File: rtl/coproc_regfile.sv
module coproc_regfile #(
  parameter int BW   = 8,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG),
  localparam int WW  = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_we,
  input  logic [IW-1:0] host_idx,
  input  logic [BW-1:0] host_d,
  input  logic          ex_we,
  input  logic          ex_wide,
  input  logic [IW-1:0] ex_idx,
  input  logic [WW-1:0] ex_d,
  input  logic          rd_wide,
  input  logic [IW-1:0] rd_a_idx,
  input  logic [IW-1:0] rd_b_idx,
  input  logic [IW-1:0] host_rd_idx,
  output logic [WW-1:0] rd_a,
  output logic [WW-1:0] rd_b,
  output logic [BW-1:0] host_q
);
  logic [BW-1:0] regs [NREG];
  logic [NREG-1:0] ex_hit;
  logic [BW-1:0]   ex_byte [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_port
    localparam logic [IW-1:0] IDX = IW'(gi);
    assign ex_hit[gi]  = ex_we && (ex_wide ? (ex_idx[IW-1:1] == IDX[IW-1:1])
                                           : (ex_idx == IDX));
    assign ex_byte[gi] = (ex_wide && IDX[0]) ? ex_d[WW-1:BW] : ex_d[BW-1:0];
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (rst)                                 regs[i] <= '0;
      else if (ex_hit[i])                      regs[i] <= ex_byte[i];
      else if (host_we && host_idx == IW'(i))  regs[i] <= host_d;
    end
  end

  function automatic logic [WW-1:0] view(input logic [IW-1:0] idx, input logic w);
    if (w) return {regs[{idx[IW-1:1], 1'b1}], regs[{idx[IW-1:1], 1'b0}]};
    return {{BW{1'b0}}, regs[idx]};
  endfunction

  assign rd_a   = view(rd_a_idx, rd_wide);
  assign rd_b   = view(rd_b_idx, rd_wide);
  assign host_q = regs[host_rd_idx];

  assert_byte_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
    ex_we && !ex_wide |=> regs[$past(ex_idx)] == $past(ex_d[BW-1:0]));

  assert_host_write_lands_R11: assert property (@(posedge clk) disable iff (rst)
    host_we && !ex_hit[host_idx] |=> regs[$past(host_idx)] == $past(host_d));

  assert_instr_wins_clash_R11: assert property (@(posedge clk) disable iff (rst)
    host_we && ex_hit[host_idx] |=> regs[$past(host_idx)] != $past(host_d)
                                    || $past(host_d) == $past(ex_byte[host_idx]));
endmodule

// File: rtl/regpair_coproc.sv
module regpair_coproc
  import coproc_pkg::*;
#(
  parameter int BW   = 8,
  parameter int NREG = 32,
  localparam int IW  = $clog2(NREG),
  localparam int HAW = IW + 1,
  localparam int WW  = 2 * BW,
  localparam int INW = OPW + 2 * IW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ins_valid,
  input  logic [INW-1:0] ins_word,
  input  logic           host_we,
  input  logic [HAW-1:0] host_addr,
  input  logic [BW-1:0]  host_wdata,
  output logic [BW-1:0]  host_rdata,
  output logic           busy
);
  localparam logic [HAW-1:0] STAT_ADDR = HAW'(NREG);

  logic [OPW-1:0] opc;
  logic [IW-1:0]  fld_a, fld_b;
  logic           legal, wide, wr_reg, upd_c, upd_zn, force_c, force_val;
  logic [FNW-1:0] fn;
  logic [WW-1:0]  op_a, op_b, res;
  logic           cout, zero, neg;
  logic [BW-1:0]  host_q;
  flags_t         flags_q;

  assign opc   = ins_word[INW-1 -: OPW];
  assign fld_a = ins_word[2*IW-1 -: IW];
  assign fld_b = ins_word[IW-1:0];
  assign busy  = 1'b0;

  coproc_decode u_dec (
    .opc(opc), .legal(legal), .wide(wide), .fn(fn), .wr_reg(wr_reg),
    .upd_c(upd_c), .upd_zn(upd_zn), .force_c(force_c), .force_val(force_val)
  );

  coproc_regfile #(.BW(BW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .host_we(host_we && host_addr < STAT_ADDR), .host_idx(host_addr[IW-1:0]),
    .host_d(host_wdata),
    .ex_we(ins_valid && wr_reg), .ex_wide(wide), .ex_idx(fld_a), .ex_d(res),
    .rd_wide(wide), .rd_a_idx(fld_a), .rd_b_idx(fld_b),
    .host_rd_idx(host_addr[IW-1:0]),
    .rd_a(op_a), .rd_b(op_b), .host_q(host_q)
  );

  coproc_alu #(.BW(BW)) u_alu (
    .a(op_a), .b(op_b), .wide(wide), .fn(fn), .cin(flags_q.c),
    .res(res), .cout(cout), .zero(zero), .neg(neg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
    end else if (ins_valid) begin
      if (!legal)  flags_q.ill <= 1'b1;
      if (upd_c)   flags_q.c   <= cout;
      if (force_c) flags_q.c   <= force_val;
      if (upd_zn) begin
        flags_q.z <= zero;
        flags_q.n <= neg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                         host_rdata <= '0;
    else if (host_addr < STAT_ADDR)  host_rdata <= host_q;
    else if (host_addr == STAT_ADDR) host_rdata <= BW'(flags_q);
    else                             host_rdata <= '0;
  end

  assert_ill_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    flags_q.ill |=> flags_q.ill);

  assert_illegal_keeps_flags_R10: assert property (@(posedge clk) disable iff (rst)
    ins_valid && !legal |=> $stable({flags_q.c, flags_q.z, flags_q.n}));

  assert_copy_keeps_flags_R7: assert property (@(posedge clk) disable iff (rst)
    ins_valid && fn == FN_MOV |=> $stable({flags_q.c, flags_q.z, flags_q.n}));

  assert_logic_keeps_carry_R8: assert property (@(posedge clk) disable iff (rst)
    ins_valid && (fn == FN_AND || fn == FN_OR || fn == FN_XOR) |=> $stable(flags_q.c));

  assert_carry_ops_keep_zn_R9: assert property (@(posedge clk) disable iff (rst)
    ins_valid && force_c |=> $stable({flags_q.z, flags_q.n}) && flags_q.c == $past(force_val));
endmodule

// File: tb/regpair_coproc_test.sv
module regpair_coproc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [15:0] ins_word = '0;
  logic        host_we = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  regpair_coproc uut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .busy(busy)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        cin;
    logic [5:0]  op;
    logic [15:0] exp;
    logic [2:0]  nzc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{16'h1234, 16'h0056, 1'b0, 6'h01, 16'h128A, 3'b100},
    '{16'h55FF, 16'h0000, 1'b1, 6'h01, 16'h5500, 3'b011},
    '{16'h80FF, 16'h8001, 1'b0, 6'h21, 16'h0100, 3'b001},
    '{16'h1234, 16'h4321, 1'b1, 6'h21, 16'h5556, 3'b000},
    '{16'h7FFF, 16'h0000, 1'b1, 6'h21, 16'h8000, 3'b100},
    '{16'hAB12, 16'h3456, 1'b1, 6'h00, 16'hAB56, 3'b011},
    '{16'h00F0, 16'h0F80, 1'b1, 6'h02, 16'h0080, 3'b101},
    '{16'h0000, 16'h00C0, 1'b0, 6'h23, 16'h00C0, 3'b000},
    '{16'hFFFF, 16'hFFFF, 1'b1, 6'h24, 16'h0000, 3'b011},
    '{16'h1111, 16'hBEEF, 1'b0, 6'h20, 16'hBEEF, 3'b010}
  };

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic hwr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic hrd(input logic [5:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a;
    @(negedge clk); d = host_rdata;
  endtask

  task automatic exec(input logic [15:0] w);
    @(negedge clk); ins_valid = 1'b1; ins_word = w;
    @(negedge clk); ins_valid = 1'b0;
  endtask

  function automatic logic [15:0] iw(input logic [5:0] op, input logic [4:0] fa, input logic [4:0] fb);
    return {op, fa, fb};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] lo, hi, st;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 rdata after reset", {8'h0, host_rdata}, 16'h0);
    hrd(6'd0, lo);  check("R1 R0 reset", {8'h0, lo}, 16'h0);
    hrd(6'd31, lo); check("R1 R31 reset", {8'h0, lo}, 16'h0);
    hrd(6'd32, lo); check("R1 status reset", {8'h0, lo}, 16'h0);
    check("R3 busy low", {15'h0, busy}, 16'h0);

    // R2: host port
    hwr(6'd31, 8'hC3);
    hrd(6'd31, lo); check("R2 R31 readback", {8'h0, lo}, 16'h00C3);
    hwr(6'd40, 8'h77);
    hrd(6'd40, lo); check("R2 high address reads 0", {8'h0, lo}, 16'h0);
    hrd(6'd31, lo); check("R2 high write ignored", {8'h0, lo}, 16'h00C3);

    // Vector walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      hwr(6'd6, VECS[v].a[7:0]);  hwr(6'd7, VECS[v].a[15:8]);
      hwr(6'd8, VECS[v].b[7:0]);  hwr(6'd9, VECS[v].b[15:8]);
      exec(iw(6'h22, 5'd24, 5'd24));
      exec(iw(VECS[v].cin ? 6'h06 : 6'h05, 5'd0, 5'd0));
      if (VECS[v].op[5]) exec(iw(VECS[v].op, 5'd7, 5'd9));
      else               exec(iw(VECS[v].op, 5'd6, 5'd8));
      hrd(6'd6, lo); hrd(6'd7, hi);
      check($sformatf("R4 R5 R6 R8 vec%0d result", v), {hi, lo}, VECS[v].exp);
      hrd(6'd8, lo); hrd(6'd9, hi);
      check($sformatf("R7 vec%0d source kept", v), {hi, lo}, VECS[v].b);
      hrd(6'd32, st);
      check($sformatf("R2 R5 R6 R7 R8 vec%0d flags", v), {8'h0, st}, {13'h0, VECS[v].nzc});
    end

    // R9: carry set/clear only
    hwr(6'd6, 8'h42);
    exec(iw(6'h22, 5'd24, 5'd24));
    exec(iw(6'h06, 5'd6, 5'd6));
    hrd(6'd32, st); check("R9 set carry", {8'h0, st}, 16'h0003);
    hrd(6'd6, lo);  check("R9 register untouched", {8'h0, lo}, 16'h0042);
    exec(iw(6'h25, 5'd6, 5'd6));
    hrd(6'd32, st); check("R9 clear carry", {8'h0, st}, 16'h0002);

    // R10: illegal opcodes
    hwr(6'd6, 8'h10); hwr(6'd7, 8'h01); hwr(6'd8, 8'h20);
    exec(iw(6'h06, 5'd0, 5'd0));
    exec(iw(6'h07, 5'd6, 5'd8));
    hrd(6'd6, lo);  check("R10 illegal byte keeps reg", {8'h0, lo}, 16'h0010);
    hrd(6'd32, st); check("R10 illegal sets ILL", {8'h0, st}, 16'h000B);
    exec(iw(6'h3F, 5'd7, 5'd9));
    hrd(6'd6, lo); hrd(6'd7, hi);
    check("R10 illegal word keeps pair", {hi, lo}, 16'h0110);
    exec(iw(6'h05, 5'd0, 5'd0));
    hrd(6'd32, st); check("R10 ILL sticky after clear carry", {8'h0, st}, 16'h000A);
    exec(iw(6'h01, 5'd6, 5'd8));
    hrd(6'd6, lo);  check("R10 legal add after illegal", {8'h0, lo}, 16'h0030);
    hrd(6'd32, st); check("R10 ILL sticky after add", {8'h0, st}, 16'h0008);

    // R11: same-edge collisions
    hwr(6'd11, 8'h77); hwr(6'd10, 8'h00);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = iw(6'h00, 5'd10, 5'd11);
    host_we = 1'b1; host_addr = 6'd10; host_wdata = 8'h99;
    @(negedge clk); ins_valid = 1'b0; host_we = 1'b0;
    hrd(6'd10, lo); check("R11 instruction wins clash", {8'h0, lo}, 16'h0077);

    hwr(6'd13, 8'h21);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = iw(6'h00, 5'd10, 5'd13); host_addr = 6'd10;
    @(negedge clk); ins_valid = 1'b0;
    check("R11 read returns old value", {8'h0, host_rdata}, 16'h0077);
    hrd(6'd10, lo); check("R11 new value after edge", {8'h0, lo}, 16'h0021);

    @(negedge clk);
    ins_valid = 1'b1; ins_word = iw(6'h00, 5'd14, 5'd11);
    host_we = 1'b1; host_addr = 6'd12; host_wdata = 8'h5A;
    @(negedge clk); ins_valid = 1'b0; host_we = 1'b0;
    hrd(6'd14, lo); check("R11 instruction write lands", {8'h0, lo}, 16'h0077);
    hrd(6'd12, lo); check("R11 host write lands", {8'h0, lo}, 16'h005A);
    check("R3 busy still low", {15'h0, busy}, 16'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule